// File: doc/BRIEF.md
# SPI Register-Access Master with Device Wait States

This block performs one register read or one register write towards a security device attached over SPI. Every access fits in a single chip-select window. The master first sends a four-byte command header that carries the direction, the transfer length and a 24-bit register address. The device may then hold the transfer off. After the hold-off ends, between 1 and 64 data bytes move in the requested direction. Chip select is released when the last data byte completes.

The device signals a hold-off on the final bit of the header. While it holds, the master keeps chip select low and clocks whole filler bytes of zeros. It keeps doing so until a received byte ends in a 1. If the hold-off outlasts a programmable limit, the master releases chip select, drops the access and reports an error.

The device may fall asleep when the bus has been quiet for a long time. As an option, an access that follows such a quiet period is preceded by a short chip-select pulse, which wakes the device, and then by a recovery gap. Every length of time is a count of system clock cycles set by a parameter.

Top module: `spi_regx_master`

## Requirements
- R1: Header byte 0 is {dir, 1, n-1}: bit 7 is 1 for a read and 0 for a write, bit 6 is always 1, and bits 5:0 hold the byte count minus one (xfer_len_m1).
- R2: Header bytes 1, 2 and 3 carry the address bits 23:16, 15:8 and 7:0, in that order.
- R3: When the MISO bit sampled on the eighth clock of header byte 3 is 1, the first data byte follows directly, with no filler byte in between.
- R4: When that bit is 0, the master clocks filler bytes with MOSI held at 0 and chip select held low. It does this until a filler byte whose last received bit (bit 0) is 1 has completed, and only then starts the data phase.
- R5: If a hold-off lasts STALL_TIMEOUT cycles, the master releases chip select and pulses err for one cycle. It does not pulse done and delivers no read data.
- R6: With WAKE_EN set, an access that is requested while the idle window has expired first drives chip select low for WAKE_LOW_CYC cycles with no SCLK edges. It then holds chip select high for WAKE_GAP_CYC cycles before the header starts. The window is treated as expired after reset.
- R7: The end of any access, whether it completes or times out, restarts the idle window. An access requested within IDLE_WINDOW cycles of that end sends no wake pulse.
- R8: A window carries exactly 4 + filler + n bytes. Chip select rises when the last data byte completes, on the same cycle that done pulses for one cycle.
- R9: SPI mode 0 is used. SCLK is low whenever chip select is high, SCLK runs at the system clock divided by CLK_DIV, bytes go out MSB first, MOSI changes only while SCLK is low, and MISO is sampled on the rising SCLK edge.
- R10: A start pulse that arrives while an access is in progress is ignored. After done or err, no further window appears without a new start.
- R11: In a read, each data byte appears on rd_data with a one-cycle rd_valid pulse, in order. In a write, wr_pop pulses once per data byte in the cycle that wr_data is taken, and the bytes are sent in that order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to begin an access |
| rd_nwr | input | 1 | 1 = read, 0 = write; sampled with start |
| xfer_len_m1 | input | 6 | Byte count minus one; sampled with start |
| addr | input | 24 | Register address; sampled with start |
| wr_data | input | 8 | Write byte; must be valid while wr_pop is high |
| wr_pop | output | 1 | Write byte consumed this cycle |
| rd_data | output | 8 | Received data byte |
| rd_valid | output | 1 | rd_data holds a new byte |
| done | output | 1 | Access completed |
| err | output | 1 | Access dropped after hold-off timeout |
| sclk | output | 1 | SPI clock |
| mosi | output | 1 | Master-to-device data |
| miso | input | 1 | Device-to-master data |
| cs_n | output | 1 | Active-low chip select |

## Verification
A behavioural device on the bench answers with a configurable number of hold-off bytes. The number used is zero, one, two, three, or one so large that the device never releases, which separates direct entry, polling loops of several lengths, and the timeout abort. Reads and writes of 1, 4 and 64 bytes with distinct address patterns check the length field, the direction bit and the address byte order. A data pattern that is unique per position shows up any lost, repeated or reordered byte. Accesses are issued right after the previous one, right after a timeout, and after a quiet period longer than the idle window, to tell a required wake pulse from one that should be skipped. A second start issued in the middle of an access, with different parameters, must leave both that access and the bus after it unchanged.

// File: rtl/spi_regx_pkg.sv
package spi_regx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAKE_LO,
    ST_WAKE_GAP,
    ST_HDR,
    ST_POLL,
    ST_DATA
  } xfer_state_t;

  // Command header byte for position idx of the four-byte header
  function automatic logic [7:0] hdr_byte(input logic rd, input logic [5:0] len_m1,
                                          input logic [23:0] adr, input logic [1:0] idx);
    case (idx)
      2'd0:    hdr_byte = {rd, 1'b1, len_m1};
      2'd1:    hdr_byte = adr[23:16];
      2'd2:    hdr_byte = adr[15:8];
      default: hdr_byte = adr[7:0];
    endcase
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    max3 = (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/spi_regx_shifter.sv
module spi_regx_shifter #(
  parameter int CLK_DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic       abort,
  input  logic [7:0] tx_byte,
  input  logic       miso,
  output logic       sclk,
  output logic       mosi,
  output logic       busy,
  output logic       done,
  output logic [7:0] rx_byte
);
  localparam int HALF = CLK_DIV / 2;
  localparam int HW   = (HALF > 1) ? $clog2(HALF) : 1;

  logic [HW-1:0] hcnt;
  logic [2:0]    bitn;
  logic [7:0]    sh;
  logic          half_end;

  assign half_end = (hcnt == HW'(HALF - 1));
  assign mosi     = busy & sh[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      sclk    <= 1'b0;
      hcnt    <= '0;
      bitn    <= '0;
      sh      <= '0;
      rx_byte <= '0;
    end else begin
      done <= 1'b0;
      if (abort) begin
        busy <= 1'b0;
        sclk <= 1'b0;
      end else if (go && !busy) begin
        busy <= 1'b1;
        sh   <= tx_byte;
        bitn <= '0;
        hcnt <= '0;
        sclk <= 1'b0;
      end else if (busy) begin
        if (half_end) begin
          hcnt <= '0;
          if (!sclk) begin
            sclk    <= 1'b1;
            rx_byte <= {rx_byte[6:0], miso};
          end else begin
            sclk <= 1'b0;
            if (bitn == 3'd7) begin
              busy <= 1'b0;
              done <= 1'b1;
            end else begin
              bitn <= bitn + 3'd1;
              sh   <= {sh[6:0], 1'b0};
            end
          end
        end else begin
          hcnt <= hcnt + HW'(1);
        end
      end
    end
  end

  // R9: clock pulses only inside a byte
  a_r9_sclk_in_byte: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> busy);
  // R9: data line steady across the high phase of SCLK
  a_r9_mosi_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi));

endmodule

// File: rtl/spi_regx_idle_tracker.sv
module spi_regx_idle_tracker #(
  parameter int WINDOW = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic activity,
  output logic expired
);
  localparam int CW = $clog2(WINDOW + 1);

  logic [CW-1:0] cnt;

  assign expired = (cnt == CW'(WINDOW));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= CW'(WINDOW);
    else if (activity)      cnt <= '0;
    else if (!expired)      cnt <= cnt + CW'(1);
  end

  // R7: bus activity always reopens the window
  a_r7_window_restart: assert property (@(posedge clk) disable iff (!rst_n)
    activity |=> !expired);

endmodule

// File: rtl/spi_regx_master.sv
module spi_regx_master
  import spi_regx_pkg::*;
#(
  parameter int CLK_DIV       = 4,
  parameter int STALL_TIMEOUT = 50000,
  parameter int IDLE_WINDOW   = 90000,
  parameter int WAKE_LOW_CYC  = 50,
  parameter int WAKE_GAP_CYC  = 5000,
  parameter bit WAKE_EN       = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        rd_nwr,
  input  logic [5:0]  xfer_len_m1,
  input  logic [23:0] addr,
  input  logic [7:0]  wr_data,
  output logic        wr_pop,
  output logic [7:0]  rd_data,
  output logic        rd_valid,
  output logic        done,
  output logic        err,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso,
  output logic        cs_n
);
  localparam int TMR_MAX = max3(STALL_TIMEOUT, WAKE_LOW_CYC, WAKE_GAP_CYC);
  localparam int TW      = $clog2(TMR_MAX + 1);

  xfer_state_t   state_q;
  logic          rd_q;
  logic [5:0]    len_q;
  logic [23:0]   addr_q;
  logic [5:0]    idx_q;
  logic [TW-1:0] tmr_q;

  logic          sh_busy, sh_done;
  logic [7:0]    sh_rx;
  logic          in_window, need_byte, stall_to, xfer_end, idle_expired, wake_needed;
  logic [7:0]    tx_byte;

  assign in_window = (state_q == ST_HDR) || (state_q == ST_POLL) || (state_q == ST_DATA);
  assign need_byte = in_window && !sh_busy && !sh_done;
  assign stall_to  = (state_q == ST_POLL) && (tmr_q == TW'(STALL_TIMEOUT - 1));
  assign xfer_end  = stall_to || ((state_q == ST_DATA) && sh_done && (idx_q == len_q));
  assign wr_pop    = need_byte && (state_q == ST_DATA) && !rd_q;
  assign cs_n      = !(in_window || (state_q == ST_WAKE_LO));
  assign wake_needed = WAKE_EN && idle_expired;

  always_comb begin
    case (state_q)
      ST_HDR:  tx_byte = hdr_byte(rd_q, len_q, addr_q, idx_q[1:0]);
      ST_DATA: tx_byte = rd_q ? 8'h00 : wr_data;
      default: tx_byte = 8'h00;
    endcase
  end

  spi_regx_shifter #(.CLK_DIV(CLK_DIV)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .go      (need_byte),
    .abort   (stall_to),
    .tx_byte (tx_byte),
    .miso    (miso),
    .sclk    (sclk),
    .mosi    (mosi),
    .busy    (sh_busy),
    .done    (sh_done),
    .rx_byte (sh_rx)
  );

  spi_regx_idle_tracker #(.WINDOW(IDLE_WINDOW)) u_idle (
    .clk      (clk),
    .rst_n    (rst_n),
    .activity (xfer_end),
    .expired  (idle_expired)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      rd_q     <= 1'b0;
      len_q    <= '0;
      addr_q   <= '0;
      idx_q    <= '0;
      tmr_q    <= '0;
      done     <= 1'b0;
      err      <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      done     <= 1'b0;
      err      <= 1'b0;
      rd_valid <= 1'b0;
      case (state_q)
        ST_IDLE: if (start) begin
          rd_q    <= rd_nwr;
          len_q   <= xfer_len_m1;
          addr_q  <= addr;
          idx_q   <= '0;
          tmr_q   <= '0;
          state_q <= wake_needed ? ST_WAKE_LO : ST_HDR;
        end
        ST_WAKE_LO: begin
          if (tmr_q == TW'(WAKE_LOW_CYC - 1)) begin
            tmr_q   <= '0;
            state_q <= ST_WAKE_GAP;
          end else tmr_q <= tmr_q + TW'(1);
        end
        ST_WAKE_GAP: begin
          if (tmr_q == TW'(WAKE_GAP_CYC - 1)) begin
            tmr_q   <= '0;
            state_q <= ST_HDR;
          end else tmr_q <= tmr_q + TW'(1);
        end
        ST_HDR: if (sh_done) begin
          if (idx_q == 6'd3) begin
            idx_q   <= '0;
            tmr_q   <= '0;
            state_q <= sh_rx[0] ? ST_DATA : ST_POLL;
          end else idx_q <= idx_q + 6'd1;
        end
        ST_POLL: begin
          tmr_q <= tmr_q + TW'(1);
          if (stall_to) begin
            err     <= 1'b1;
            state_q <= ST_IDLE;
          end else if (sh_done && sh_rx[0]) begin
            idx_q   <= '0;
            state_q <= ST_DATA;
          end
        end
        ST_DATA: if (sh_done) begin
          if (rd_q) begin
            rd_valid <= 1'b1;
            rd_data  <= sh_rx;
          end
          if (idx_q == len_q) begin
            done    <= 1'b1;
            state_q <= ST_IDLE;
          end else idx_q <= idx_q + 6'd1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R9: clock idles low outside a window
  a_r9_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);
  // R8: completion coincides with a released select
  a_r8_done_released: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cs_n);
  // R5: timeout releases the bus and never also completes
  a_r5_err_released: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (cs_n && !done));
  // R4: filler bytes carry zeros
  a_r4_poll_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_POLL) |-> !mosi);
  // R10: request fields frozen while busy
  a_r10_ignore_start: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |=> ($stable(addr_q) && $stable(len_q) && $stable(rd_q)));
  // R7: no wake pulse inside the window
  a_r7_skip_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && start && !idle_expired) |=> (state_q == ST_HDR));
  // R3: ready bit set leads straight to data
  a_r3_direct_data: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HDR && sh_done && idx_q == 6'd3 && sh_rx[0]) |=> (state_q == ST_DATA));

endmodule

// File: tb/spi_regx_master_tb.sv
module spi_regx_master_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DIV   = 4;
  localparam int STALL = 400;
  localparam int IDLE  = 2000;
  localparam int WLOW  = 6;
  localparam int WGAP  = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, rd_nwr = 1'b0, miso = 1'b0;
  logic [5:0] xfer_len_m1 = '0;
  logic [23:0] addr = '0;
  logic [7:0] wr_data = '0;
  logic wr_pop, rd_valid, done, err, sclk, mosi, cs_n;
  logic [7:0] rd_data;

  int n_cmp = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_regx_master #(.CLK_DIV(DIV), .STALL_TIMEOUT(STALL), .IDLE_WINDOW(IDLE),
                    .WAKE_LOW_CYC(WLOW), .WAKE_GAP_CYC(WGAP), .WAKE_EN(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .rd_nwr(rd_nwr), .xfer_len_m1(xfer_len_m1),
    .addr(addr), .wr_data(wr_data), .wr_pop(wr_pop), .rd_data(rd_data), .rd_valid(rd_valid),
    .done(done), .err(err), .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n));

  function automatic logic [7:0] rpat(input int j);
    rpat = 8'(j * 37 + 11) ^ 8'h5A;
  endfunction
  function automatic logic [7:0] wpat(input int j);
    wpat = 8'(j * 13 + 7);
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---- behavioural device ----
  int stall_cfg = 0;
  int nb = 0;
  logic [7:0] sh_in = '0;
  logic [7:0] cap[$];
  logic [7:0] last_cap[$];

  function automatic logic dev_bit(input int n);
    int b, p;
    logic [7:0] t;
    b = n / 8;
    p = 7 - (n % 8);
    if (b < 3) return 1'b0;
    if (b == 3) return (p == 0) && (stall_cfg == 0);
    if (b < 4 + stall_cfg) return (p == 0) && (b == 3 + stall_cfg);
    t = rpat(b - 4 - stall_cfg);
    return t[p];
  endfunction

  always @(negedge cs_n) begin
    nb = 0;
    cap.delete();
    miso = dev_bit(0);
  end
  always @(posedge sclk) if (!cs_n) begin
    sh_in = {sh_in[6:0], mosi};
    nb++;
    if (nb % 8 == 0) cap.push_back(sh_in);
  end
  always @(negedge sclk) if (!cs_n) miso = dev_bit(nb);

  // ---- window bookkeeping and per-clock mode check ----
  int n_win = 0, lowcnt = 0, highcnt = 0, gap_before = 0;
  int win_low[$], win_bits[$], win_gap[$];
  logic cs_prev = 1'b1;
  logic [7:0] rxq[$];
  int widx = 0;
  bit pend = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      chk(!(cs_n && sclk), "R9 sclk idle low", sclk, 0);
      if (!cs_n) begin
        if (cs_prev) begin gap_before = highcnt; lowcnt = 1; end
        else lowcnt++;
      end else begin
        if (!cs_prev) begin
          win_low.push_back(lowcnt); win_bits.push_back(nb); win_gap.push_back(gap_before);
          last_cap = cap; n_win++; highcnt = 1;
        end else highcnt++;
      end
      cs_prev = cs_n;
      if (rd_valid) rxq.push_back(rd_data);
      if (pend) begin widx++; wr_data = wpat(widx); end
      pend = wr_pop;
    end
  end

  task automatic run_xact(input bit rd, input int len, input logic [23:0] a, input int stl,
                          input bit exp_wake, input bit dup, input bit exp_err);
    int w0, cyc, nwin_exp, tot;
    logic [7:0] h0;
    stall_cfg = stl;
    widx = 0; wr_data = wpat(0); rxq.delete();
    w0 = n_win;
    @(negedge clk);
    start = 1'b1; rd_nwr = rd; xfer_len_m1 = 6'(len - 1); addr = a;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!(done || err) && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      if (dup && cyc == 40) begin start = 1'b1; rd_nwr = ~rd; addr = ~a; xfer_len_m1 = 6'd0; end
      if (dup && cyc == 41) start = 1'b0;
    end
    if (exp_err) begin
      chk(err === 1'b1 && done === 1'b0, "R5 err without done", {done, err}, 2'b01);
      chk(cs_n === 1'b1, "R5 cs released at err", cs_n, 1);
      chk(cyc >= STALL && cyc <= STALL + 4 * (8 * DIV + 2) + 40, "R5 timeout cycles", cyc, STALL);
    end else begin
      chk(done === 1'b1 && err === 1'b0, "R8 done without err", {done, err}, 2'b10);
      chk(cs_n === 1'b1, "R8 cs released at done", cs_n, 1);
    end
    repeat (3) @(negedge clk);
    nwin_exp = exp_wake ? 2 : 1;
    chk(n_win - w0 == nwin_exp, exp_wake ? "R6 wake window count" : "R7 no wake window", n_win - w0, nwin_exp);
    if (exp_wake && n_win - w0 == 2) begin
      chk(win_low[w0] == WLOW && win_bits[w0] == 0, "R6 wake pulse width", win_low[w0], WLOW);
      chk(win_gap[w0 + 1] == WGAP, "R6 wake gap", win_gap[w0 + 1], WGAP);
    end
    if (exp_err) begin
      chk(rxq.size() == 0, "R5 no read data", rxq.size(), 0);
    end else if (last_cap.size() >= 4) begin
      tot = 4 + stl + len;
      h0 = {rd, 1'b1, 6'(len - 1)};
      chk(last_cap.size() == tot && win_bits[n_win - 1] == 8 * tot, "R8 window bytes", last_cap.size(), tot);
      chk(last_cap[0] == h0, "R1 header byte0", last_cap[0], h0);
      chk({last_cap[1], last_cap[2], last_cap[3]} == a, "R2 address order",
          {last_cap[1], last_cap[2], last_cap[3]}, a);
      for (int k = 0; k < stl && 4 + k < last_cap.size(); k++)
        chk(last_cap[4 + k] == 8'h00, stl == 0 ? "R3 no filler" : "R4 filler zero", last_cap[4 + k], 0);
      if (rd) begin
        chk(rxq.size() == len, "R11 read count", rxq.size(), len);
        for (int j = 0; j < len && j < rxq.size(); j++)
          chk(rxq[j] == rpat(j), "R11 read byte", rxq[j], rpat(j));
      end else begin
        chk(widx == len, "R11 wr_pop count", widx, len);
        for (int j = 0; j < len && 4 + stl + j < last_cap.size(); j++)
          chk(last_cap[4 + stl + j] == wpat(j), stl == 0 ? "R3 write byte" : "R4 write byte after hold",
              last_cap[4 + stl + j], wpat(j));
      end
    end else chk(0, "R8 window too short", last_cap.size(), 4 + stl + len);
    if (dup) begin
      w0 = n_win;
      repeat (200) @(negedge clk);
      chk(n_win == w0 && cs_n === 1'b1, "R10 ignored start", n_win - w0, 0);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_n === 1'b1 && sclk === 1'b0 && done === 1'b0 && err === 1'b0 && wr_pop === 1'b0,
        "R8 reset state", {cs_n, sclk, done, err, wr_pop}, 5'b10000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    run_xact(1'b0, 4,  24'hD40018, 0, 1'b1, 1'b0, 1'b0);   // first access after reset: wake
    run_xact(1'b1, 1,  24'hD40F00, 0, 1'b0, 1'b0, 1'b0);   // R7 inside window
    run_xact(1'b1, 64, 24'h123456, 3, 1'b0, 1'b0, 1'b0);   // R4 three fillers
    run_xact(1'b0, 64, 24'hA5C3E1, 2, 1'b0, 1'b0, 1'b0);   // R4 write after hold
    run_xact(1'b1, 8,  24'h000024, 100000, 1'b0, 1'b0, 1'b1); // R5 timeout
    run_xact(1'b0, 1,  24'hFEDCBA, 0, 1'b0, 1'b0, 1'b0);   // R7 window restarted by error end
    run_xact(1'b0, 4,  24'h0F0F0F, 1, 1'b0, 1'b1, 1'b0);   // R10 start during access
    repeat (IDLE + 50) @(negedge clk);
    run_xact(1'b1, 2,  24'h800001, 1, 1'b1, 1'b0, 1'b0);   // R6 wake after quiet period
    finish_run();
  end
endmodule